// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

A last-in first-out store of 64 words of 16 bits, held in a small synchronous memory and addressed by a 6-bit top-of-stack pointer. A push strobe moves the pointer up by one and writes the incoming word where the pointer now lands. A pop strobe reads the word under the pointer into a registered output and then moves the pointer down by one.

There are no separate counters for the flags. Both flags come from the pointer reaching zero, and the direction of travel decides which flag is meant. Arriving at zero on a push means every slot, including slot 0, is occupied, so the full flag is set. Arriving at zero on a pop means nothing is left, so the empty flag is set.

Misuse is absorbed rather than reported:
- A push into a full stack is ignored.
- A pop from an empty stack is ignored.
- A push and a pop in the same cycle do nothing.

Top module: `lifo_regstack`

## Requirements
- R1: After a synchronous active-high reset, the pointer reads 0, the empty flag is 1, the full flag is 0 and the popped-word output is 0.
- R2: An accepted push (push strobe high, pop strobe low, full flag low) raises the pointer by one, modulo 64. It stores the input word at the raised pointer value.
- R3: An accepted push clears the empty flag. It sets the full flag when the raised pointer equals 0. The full and empty flags are never 1 together.
- R4: An accepted pop (pop strobe high, push strobe low, empty flag low) places the word stored at the current pointer on the popped-word output, valid from the cycle after the strobe. It lowers the pointer by one.
- R5: An accepted pop clears the full flag. It sets the empty flag when the lowered pointer equals 0.
- R6: A push while the full flag is 1 (pop strobe low) changes nothing: the pointer, flags and stored words stay the same, and the popped-word output keeps its value.
- R7: A pop while the empty flag is 1 (push strobe low) changes nothing: the pointer, flags and popped-word output keep their values.
- R8: Push and pop strobes high in the same cycle act as no operation. The pointer, flags, stored words and popped-word output keep their values.
- R9: The stack holds 64 words, slot 0 included. After 64 pushes from empty, 64 pops return the words in reverse order of pushing.
- R10: The popped-word output changes only on the cycle after an accepted pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push strobe, one cycle per word |
| pop_req | input | 1 | Pop strobe, one cycle per word |
| push_data | input | 16 | Word to push |
| pop_data | output | 16 | Last popped word, registered |
| top_ptr | output | 6 | Pointer to the top item |
| is_full | output | 1 | All 64 slots occupied |
| is_empty | output | 1 | No item held |

## Verification
The assertions assume that each strobe is meant as one request per clock cycle. They also assume the strobes are never X after reset, because a request is judged only at the rising edge.

The bench drives strobes as clean levels for one whole cycle. It changes them only on the falling edge. Its random phases alternate between push-biased and pop-biased mixes, so that the pointer reaches both wrap points. Every combination of the two strobes occurs, including both high at once, as part of the normal input space.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stack_op_e;

  function automatic stack_op_e pick_op(input logic push, input logic pop,
                                        input logic full, input logic empty);
    stack_op_e r;
    r = OP_NONE;
    if (push && !pop && !full)
      r = OP_PUSH;
    else if (pop && !push && !empty)
      r = OP_POP;
    return r;
  endfunction

endpackage

// File: rtl/regstack_arb.sv
module regstack_arb
  import regstack_pkg::*;
(
  input  logic      push_req,
  input  logic      pop_req,
  input  logic      full,
  input  logic      empty,
  output stack_op_e op
);

  always_comb begin
    op = pick_op(push_req, pop_req, full, empty);
  end

endmodule

// File: rtl/regstack_ptr.sv
module regstack_ptr
  import regstack_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  stack_op_e     op,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] up_addr,
  output logic          full,
  output logic          empty
);

  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] ZERO = '0;

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_up;
  logic [AW-1:0] ptr_dn;
  logic          full_q;
  logic          empty_q;

  assign ptr_up = ptr_q + ONE;
  assign ptr_dn = ptr_q - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= ZERO;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      case (op)
        OP_PUSH: begin
          ptr_q   <= ptr_up;
          empty_q <= 1'b0;
          if (ptr_up == ZERO) full_q <= 1'b1;
        end
        OP_POP: begin
          ptr_q  <= ptr_dn;
          full_q <= 1'b0;
          if (ptr_dn == ZERO) empty_q <= 1'b1;
        end
        default: begin
          ptr_q <= ptr_q;
        end
      endcase
    end
  end

  assign ptr     = ptr_q;
  assign up_addr = ptr_up;
  assign full    = full_q;
  assign empty   = empty_q;

endmodule

// File: rtl/regstack_mem.sv
module regstack_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (re)
      rdata_q <= store[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
  import regstack_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] pop_data,
  output logic [AW-1:0] top_ptr,
  output logic          is_full,
  output logic          is_empty
);

  stack_op_e     op;
  logic [AW-1:0] ptr;
  logic [AW-1:0] up_addr;
  logic          full;
  logic          empty;

  regstack_arb u_arb (
    .push_req (push_req),
    .pop_req  (pop_req),
    .full     (full),
    .empty    (empty),
    .op       (op)
  );

  regstack_ptr #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .ptr     (ptr),
    .up_addr (up_addr),
    .full    (full),
    .empty   (empty)
  );

  regstack_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (op == OP_PUSH),
    .waddr (up_addr),
    .wdata (push_data),
    .re    (op == OP_POP),
    .raddr (ptr),
    .rdata (pop_data)
  );

  assign top_ptr  = ptr;
  assign is_full  = full;
  assign is_empty = empty;

endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          push_req,
  input logic          pop_req,
  input logic [DW-1:0] pop_data,
  input logic [AW-1:0] top_ptr,
  input logic          is_full,
  input logic          is_empty
);

  logic acc_push;
  logic acc_pop;
  assign acc_push = push_req && !pop_req && !is_full;
  assign acc_pop  = pop_req && !push_req && !is_empty;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (top_ptr == '0 && is_empty && !is_full && pop_data == '0)); // R1
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    acc_push |=> top_ptr == AW'($past(top_ptr) + AW'(1))); // R2
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst)
    (acc_push && top_ptr == {AW{1'b1}}) |=> is_full); // R3
  AST_PUSH_UNEMPTY: assert property (@(posedge clk) disable iff (rst)
    acc_push |=> !is_empty); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(is_full && is_empty)); // R3
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    acc_pop |=> top_ptr == AW'($past(top_ptr) - AW'(1))); // R4
  AST_POP_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (acc_pop && top_ptr == AW'(1)) |=> is_empty); // R5
  AST_POP_UNFULL: assert property (@(posedge clk) disable iff (rst)
    acc_pop |=> !is_full); // R5
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && is_full) |=> ($stable(top_ptr) && is_full && $stable(pop_data))); // R6
  AST_EMPTY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && is_empty) |=> ($stable(top_ptr) && is_empty && $stable(pop_data))); // R7
  AST_BOTH_NOOP: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req) |=> ($stable(top_ptr) && $stable(is_full) && $stable(is_empty) && $stable(pop_data))); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_pop |=> $stable(pop_data)); // R10

endmodule

bind lifo_regstack lifo_regstack_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .push_req (push_req),
  .pop_req  (pop_req),
  .pop_data (pop_data),
  .top_ptr  (top_ptr),
  .is_full  (is_full),
  .is_empty (is_empty)
);

// File: tb/lifo_regstack_bench.sv
`timescale 1ns/1ps
module lifo_regstack_bench;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_req = 1'b0;
  logic          pop_req = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic [AW-1:0] top_ptr;
  logic          is_full;
  logic          is_empty;

  always #4 clk = ~clk;

  lifo_regstack #(.AW(AW), .DW(DW)) u_lifo_regstack (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .pop_data(pop_data), .top_ptr(top_ptr),
    .is_full(is_full), .is_empty(is_empty)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_sp;
  logic          m_full;
  logic          m_empty;
  logic [DW-1:0] m_out;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "top_ptr", 32'(top_ptr), 32'(m_sp));
    chk(tag, "is_full", 32'(is_full), 32'(m_full));
    chk(tag, "is_empty", 32'(is_empty), 32'(m_empty));
    chk(tag, "pop_data", 32'(pop_data), 32'(m_out));
  endtask

  function automatic string classify(input logic p, input logic q);
    if (p && q) return "R8";
    if (p && m_full) return "R6";
    if (q && m_empty) return "R7";
    if (p && m_sp == AW'(DEPTH - 1)) return "R3";
    if (p) return "R2";
    if (q && m_sp == AW'(1)) return "R5";
    if (q) return "R4";
    return "R10";
  endfunction

  task automatic model(input logic p, input logic q, input logic [DW-1:0] d);
    if (p && !q && !m_full) begin
      m_sp = m_sp + AW'(1);
      m_mem[m_sp] = d;
      m_empty = 1'b0;
      if (m_sp == '0) m_full = 1'b1;
    end else if (q && !p && !m_empty) begin
      m_out = m_mem[m_sp];
      m_sp = m_sp - AW'(1);
      m_full = 1'b0;
      if (m_sp == '0) m_empty = 1'b1;
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [DW-1:0] d, input string force_tag);
    string tag;
    @(negedge clk);
    push_req = p; pop_req = q; push_data = d;
    tag = (force_tag != "") ? force_tag : classify(p, q);
    model(p, q, d);
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    compare(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_sp = '0; m_full = 1'b0; m_empty = 1'b1; m_out = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1");

    step(1'b0, 1'b1, 16'h0, "R7");
    step(1'b1, 1'b1, 16'hdead, "R8");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 16'(16'h1000 + i), "R9");
    chk("R3", "full after 64 pushes", 32'(is_full), 32'd1);
    step(1'b1, 1'b0, 16'hbeef, "R6");
    step(1'b1, 1'b1, 16'hcafe, "R8");
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 1'b1, 16'h0, "R9");
      chk("R9", "lifo order", 32'(pop_data), 32'(16'h1000 + DEPTH - 1 - i));
    end
    chk("R5", "empty after draining", 32'(is_empty), 32'd1);
    step(1'b0, 1'b1, 16'h0, "R7");
    step(1'b0, 1'b0, 16'h0, "R10");

    for (int phase = 0; phase < 24; phase++) begin
      int bias = (phase % 2 == 0) ? 80 : 20;
      for (int k = 0; k < 120; k++) begin
        int r = int'($urandom_range(99, 0));
        logic p = (r < bias);
        logic q = !p || ($urandom_range(9, 0) == 0);
        if ($urandom_range(7, 0) == 0) begin p = 1'b0; q = 1'b0; end
        step(p, q, 16'($urandom), "");
      end
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_sp = '0; m_full = 1'b0; m_empty = 1'b1; m_out = '0;
    @(negedge clk);
    compare("R1");
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_up();
    end
  end

endmodule